// File: doc/BRIEF.md
# Block-Transfer Register Slave for a Two-Wire Bus

This block is a serial slave on an SMBus-style two-wire bus. It owns a bank of ten 8-bit configuration registers and answers only block transfers. A block write sends a command of zero, then a byte count, then data bytes. A block read sends a command of zero, then a repeated start with the read address. The slave replies with a byte count and then the register contents. Both directions always start at register 0 and walk upward, one register per byte, most significant bit first.

SCL and SDA are sampled in the system clock domain. SDA is driven only through an open-drain enable: when the enable is high, the pin is pulled low. The stored register contents leave the block as one flat vector, so the rest of the chip can use them as static controls.

Six live pin levels are folded into read-only bits when a register is read. Register 6 is a fixed signature: a write to it is acknowledged, but the data is thrown away. Every register returns to its power-up value on reset.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, registers 0 to 9 hold 0x00, 0x07, 0x7F, 0xC7, 0x3F, 0x40, 0x13, 0x00, 0x00 and 0x00. Register i appears on cfg_o[8i+7:8i].
- R2: The slave acknowledges the address byte 0xD2 (7-bit address 0x69, write). It does not acknowledge any other address byte. After a mismatch it never drives SDA and changes no register until the next start.
- R3: A block write is accepted as command 0x00, then a count byte, then data bytes. The slave acknowledges each of these bytes. Each byte is received MSB first, and data byte k lands in register k, counting from 0.
- R4: A command byte other than 0x00 is not acknowledged. The data that follows it is ignored and changes no register.
- R5: A stop after any complete data byte ends the write. Registers written before the stop keep their new values, and the later registers keep their old values.
- R6: A write to register 6 is acknowledged, and register 6 keeps 0x13.
- R7: Data bytes beyond register 9 are acknowledged and have no effect.
- R8: A block read is: address 0xD2, command 0x00, repeated start, address 0xD3. The slave acknowledges each of these bytes. It then sends the count byte 10, followed by registers 0, 1 and onward, MSB first, for as long as the master acknowledges.
- R9: A byte that the master does not acknowledge ends the read, and the slave releases SDA. A read beyond register 9 returns 0xFF.
- R10: Register 0 bits 4:0 read as live_pins_i[4:0], and register 1 bit 7 reads as live_pins_i[5]. These levels are taken at the time of the read. Writes to these bits have no effect.
- R11: The slave changes its SDA drive only while SCL is low, except at a start or a stop. It releases SDA after every stop.
- R12: If the read address 0xD3 arrives with no block command earlier in the same transfer, it is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| live_pins_i | input | 6 | Live pin levels shown in read-only bits |
| cfg_o | output | 80 | Stored register contents, register i at bits 8i+7:8i |

## Verification
Two of the block's functions act on register 0 at the same time. A bus write updates the upper bits, which can be written. The live pin overlay supplies the lower bits, which are read-only. The bench writes all-ones and random bytes into register 0 and changes live_pins_i between the write and the read-back. It then judges the read byte in two parts: the upper bits must hold the written data, and the lower bits must show the pin levels at the time of the read. It also checks that cfg_o keeps those lower bits at their reset value. Random transfers of 0 to 12 data bytes also make the pointer reach register 6 and run past the end of the bank within the same transfer. Each of these transfers is judged against a bench model of the registers.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam int LIVE_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_WR,
    PH_TX,
    PH_SKIP
  } phase_t;

  // power-up value of each register
  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      6:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  // bits the bus may change
  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hE0;
      1:       return 8'h7F;
      6:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // bits replaced by live pin levels on read
  function automatic logic [BYTE_W-1:0] reg_livemask(input int idx);
    case (idx)
      0:       return 8'h1F;
      1:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] live_bits(input int idx,
                                                  input logic [LIVE_W-1:0] lv);
    case (idx)
      0:       return {3'b000, lv[4:0]};
      1:       return {lv[5], 7'b0000000};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [2:0] scl_q;
  logic [2:0] sda_q;

  // two flops of synchronisation plus one of history; idle bus reads high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 10,
  parameter int AW   = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_idx_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  input  logic [AW-1:0]          rd_idx_i,
  input  logic [LIVE_W-1:0]      live_i,
  output logic [BYTE_W-1:0]      rd_data_o,
  output logic [NREG*BYTE_W-1:0] cfg_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] WM = reg_wmask(i);
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= reg_default(i);
      else if (wr_en_i && wr_idx_i == AW'(i))
        q <= (q & ~WM) | (wr_data_i & WM);
    end

    assign cfg_o[i*BYTE_W +: BYTE_W] = q;

    if (WM == 8'h00) begin : g_fixed
      AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == AW'(i)) |=> $stable(q)); // R6
    end else begin : g_wr
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == AW'(i)) |=> ((q & WM) == ($past(wr_data_i) & WM))); // R3
    end
  end

  // read mux: stored bits with live overlay, 0xFF beyond the bank
  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx_i == AW'(i))
        rd_data_o = (cfg_o[i*BYTE_W +: BYTE_W] & ~reg_livemask(i)) | live_bits(i, live_i);
    end
  end

endmodule

// File: rtl/smb_cfg_engine.sv
module smb_cfg_engine
  import smb_cfg_pkg::*;
#(
  parameter int         NREG     = 10,
  parameter int         AW       = $clog2(NREG + 1),
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_idx_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);

  localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NREG);
  localparam logic [AW-1:0]     PTR_END  = AW'(NREG);

  phase_t            phase, nxt;
  logic [3:0]        cnt;
  logic              in_ack;
  logic              mack;
  logic              blk_ok;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txsh;
  logic [AW-1:0]     ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      nxt       <= PH_IDLE;
      cnt       <= '0;
      in_ack    <= 1'b0;
      mack      <= 1'b0;
      blk_ok    <= 1'b0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        phase    <= PH_IDLE;
        sda_oe_o <= 1'b0;
        in_ack   <= 1'b0;
        cnt      <= '0;
        blk_ok   <= 1'b0;
      end else if (start_i) begin
        phase    <= PH_ADDR;
        sda_oe_o <= 1'b0;
        in_ack   <= 1'b0;
        cnt      <= '0;
      end else begin
        case (phase)
          PH_ADDR, PH_CMD, PH_CNT, PH_WR: begin
            if (rise_i && !in_ack && cnt < 4'd8) begin
              shreg <= {shreg[BYTE_W-2:0], sda_i};
              cnt   <= cnt + 4'd1;
            end else if (fall_i && !in_ack && cnt == 4'd8) begin
              in_ack <= 1'b1;
              case (phase)
                PH_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                    sda_oe_o <= 1'b1;
                    nxt      <= PH_CMD;
                    blk_ok   <= 1'b0;
                  end else if (shreg[7:1] == DEV_ADDR && blk_ok) begin
                    sda_oe_o <= 1'b1;
                    nxt      <= PH_TX;
                  end else begin
                    sda_oe_o <= 1'b0;
                    nxt      <= PH_SKIP;
                  end
                end
                PH_CMD: begin
                  if (shreg == 8'h00) begin
                    sda_oe_o <= 1'b1;
                    blk_ok   <= 1'b1;
                    nxt      <= PH_CNT;
                  end else begin
                    sda_oe_o <= 1'b0;
                    nxt      <= PH_SKIP;
                  end
                end
                PH_CNT: begin
                  sda_oe_o <= 1'b1;
                  nxt      <= PH_WR;
                  ptr      <= '0;
                end
                default: begin
                  sda_oe_o <= 1'b1;
                  nxt      <= PH_WR;
                  if (ptr < PTR_END) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= ptr;
                    wr_data_o <= shreg;
                    ptr       <= ptr + AW'(1);
                  end
                end
              endcase
            end else if (fall_i && in_ack) begin
              in_ack <= 1'b0;
              cnt    <= '0;
              phase  <= nxt;
              if (nxt == PH_TX) begin
                ptr      <= '0;
                txsh     <= CNT_BYTE;
                sda_oe_o <= ~CNT_BYTE[7];
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (fall_i && !in_ack) begin
              if (cnt < 4'd7) begin
                txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~txsh[6];
                cnt      <= cnt + 4'd1;
              end else begin
                sda_oe_o <= 1'b0;
                in_ack   <= 1'b1;
              end
            end else if (rise_i && in_ack) begin
              mack <= ~sda_i;
            end else if (fall_i && in_ack) begin
              in_ack <= 1'b0;
              cnt    <= '0;
              if (mack) begin
                txsh     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                if (ptr < PTR_END) ptr <= ptr + AW'(1);
              end else begin
                phase    <= PH_SKIP;
                sda_oe_o <= 1'b0;
              end
            end
          end
          default: begin
            sda_oe_o <= 1'b0;
          end
        endcase
      end
    end
  end

  assign rd_idx_o = ptr;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe_o) && !$past(start_i) && !$past(stop_i)) |-> !scl_i); // R11
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !sda_oe_o); // R11
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP && $past(phase) == PH_SKIP) |-> !sda_oe_o); // R2
  AST_PTR_CAP: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_END); // R7
  AST_WRITE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> blk_ok); // R4

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic [LIVE_W-1:0]          live_pins_i,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

  localparam int AW = $clog2(NUM_REGS + 1);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic              wr_en;
  logic [AW-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_line_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  smb_cfg_engine #(
    .NREG     (NUM_REGS),
    .AW       (AW),
    .DEV_ADDR (DEV_ADDR)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .start_i   (start_c),
    .stop_i    (stop_c),
    .rd_data_i (rd_data),
    .rd_idx_o  (rd_idx),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  smb_cfg_regs #(
    .NREG (NUM_REGS),
    .AW   (AW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .live_i    (live_pins_i),
    .rd_data_o (rd_data),
    .cfg_o     (cfg_o)
  );

endmodule

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;

  localparam int NR = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [5:0] live = 6'd0;
  logic sda_oe;
  logic [NR*8-1:0] cfg;
  wire line = sda_m & ~sda_oe;

  smb_cfg_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line),
    .sda_oe_o(sda_oe), .live_pins_i(live), .cfg_o(cfg)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic mon_on = 1'b0;
  int oe_seen;

  always @(posedge clk) begin
    if (!mon_on) oe_seen <= 0;
    else if (sda_oe) oe_seen <= oe_seen + 1;
  end

  function automatic logic [7:0] f_def(int i);
    case (i) 1: return 8'h07; 2: return 8'h7F; 3: return 8'hC7; 4: return 8'h3F;
      5: return 8'h40; 6: return 8'h13; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] f_wm(int i);
    case (i) 0: return 8'hE0; 1: return 8'h7F; 6: return 8'h00; default: return 8'hFF; endcase
  endfunction
  function automatic logic [7:0] f_rd(int i, logic [5:0] lv);
    if (i >= NR) return 8'hFF;
    case (i)
      0: return (mdl[0] & 8'hE0) | {3'b000, lv[4:0]};
      1: return (mdl[1] & 8'h7F) | {lv[5], 7'd0};
      default: return mdl[i];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (4) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); hp(); scl_m = 1'b0; hp();
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); b = line; hp(); scl_m = 1'b0; hp();
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int k = 7; k >= 0; k--) send_bit(d[k]);
    recv_bit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int k = 7; k >= 0; k--) begin recv_bit(b); d[k] = b; end
    send_bit(~give_ack);
  endtask

  task automatic chk_cfg(input string req);
    for (int i = 0; i < NR; i++)
      chk(cfg[i*8 +: 8] == mdl[i], req, cfg[i*8 +: 8], mdl[i]);
  endtask

  // block write of n bytes from wbuf; stop ends it early when n is short
  task automatic do_write(input int n);
    logic a;
    bit all_ok = 1'b1;
    bus_start();
    wbyte(8'hD2, a); chk(a, "R2 address 0xD2 ack", a, 1);
    wbyte(8'h00, a); chk(a, "R3 command ack", a, 1);
    wbyte(8'(n), a); chk(a, "R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], a);
      all_ok &= a;
      if (i < NR) mdl[i] = (mdl[i] & ~f_wm(i)) | (wbuf[i] & f_wm(i));
    end
    chk(all_ok, "R3 R6 R7 data acks", all_ok, 1);
    bus_stop();
    hp();
  endtask

  // block read of n data bytes into rbuf, then check against the model
  task automatic do_read(input int n, input string req);
    logic a;
    logic [7:0] c;
    bus_start();
    wbyte(8'hD2, a); chk(a, "R8 write address ack", a, 1);
    wbyte(8'h00, a); chk(a, "R8 command ack", a, 1);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    wbyte(8'hD3, a); chk(a, "R8 read address ack", a, 1);
    rbyte(c, 1'b1); chk(c == 8'd10, "R8 count byte", c, 10);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i < n - 1);
    hp();
    chk(sda_oe == 1'b0, "R9 release after master NACK", sda_oe, 0);
    bus_stop();
    hp();
    chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
    for (int i = 0; i < n; i++)
      chk(rbuf[i] == f_rd(i, live), req, rbuf[i], f_rd(i, live));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    report();
  end

  initial begin
    logic a;
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) mdl[i] = f_def(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hp();
    chk_cfg("R1 reset defaults");

    live = 6'b101101;
    do_read(NR, "R1 R10 reset read-back");

    // R2: foreign address, then traffic that must be ignored
    bus_start();
    mon_on = 1'b1;
    wbyte(8'hA4, a); chk(!a, "R2 foreign address nack", a, 0);
    wbyte(8'h00, a); wbyte(8'h02, a); wbyte(8'h55, a); wbyte(8'hAA, a);
    bus_stop();
    hp();
    chk(oe_seen == 0, "R2 SDA never driven after mismatch", oe_seen, 0);
    mon_on = 1'b0;
    chk_cfg("R2 registers unchanged");

    // R4: non-block command
    bus_start();
    wbyte(8'hD2, a);
    wbyte(8'h05, a); chk(!a, "R4 command 0x05 nack", a, 0);
    wbyte(8'h02, a); wbyte(8'h00, a); wbyte(8'h00, a);
    bus_stop();
    hp();
    chk_cfg("R4 registers unchanged");

    // R12: read address without block command
    bus_start();
    wbyte(8'hD3, a); chk(!a, "R12 read without command nack", a, 0);
    bus_stop();
    hp();

    // R6 R7: full bank plus two extra bytes
    for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'h11 * (i + 1)) ^ 8'h80;
    wbuf[6] = 8'h00;
    do_write(12);
    chk(cfg[6*8 +: 8] == 8'h13, "R6 signature keeps 0x13", cfg[6*8 +: 8], 8'h13);
    chk_cfg("R3 R7 full bank write");
    do_read(13, "R7 R9 read incl 0xFF past end");

    // R5: early stop after three bytes
    wbuf[0] = 8'h40; wbuf[1] = 8'h2A; wbuf[2] = 8'h96;
    do_write(3);
    chk_cfg("R5 early stop");

    // R10: register write and live overlay on register 0
    wbuf[0] = 8'hFF;
    do_write(1);
    chk(cfg[4:0] == 5'd0, "R10 live bits not stored", cfg[4:0], 0);
    live = 6'b011010;
    do_read(2, "R10 overlay after write");
    live = 6'b100101;
    do_read(2, "R10 overlay after pin change");

    // random transfers
    for (int t = 0; t < 14; t++) begin
      int n;
      n = int'($urandom_range(0, 12));
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      do_write(n);
      live = 6'($urandom);
      chk_cfg("R3 random write");
      do_read(12, "R8 R10 random read-back");
    end

    report();
  end

endmodule